// File: doc/BRIEF.md
# Inter-Record Gap Detector

This block watches the read strobe that a tape transport returns for each recorded byte and decides when a data block has ended. It runs entirely on the write clock. The read strobe is a level, already synchronised, that the block samples on every rising write-clock edge. While bytes keep arriving, a strobe shows up on every edge and nothing happens. When strobes stop, the block first reports a short gap. A fixed number of write-clock periods later it reports a long gap, which tells the processor that the check-word time has come.

Internally there are two counting stages in a chain. The first stage counts consecutive edges with no strobe. When it reaches its limit it raises a one-cycle short-gap pulse and arms the second stage. The second stage then counts further strobe-free edges and raises a one-cycle long-gap pulse at its own limit. A strobe sampled high clears both stages and disarms the second stage. A gap therefore yields at most one pulse of each kind, and a fresh gap must follow a strobe. The block carries no data, so it has no stream handshake. Its only pins are the clock, the reset, the strobe and the two pulses.

Top module: `gap_detector`

## Requirements
- R1: While `rst_n` is low, and on the first edges after it rises before any gap can form, `short_gap` and `long_gap` are 0.
- R2: `short_gap` is 1 for exactly one clock cycle. It is set by the rising edge that samples `rd_strobe` low for the SHORT_LEN-th consecutive time (default 2), and it is visible from that edge until the next one.
- R3: A rising edge that samples `rd_strobe` high clears the miss count, so a run shorter than SHORT_LEN gives no `short_gap`. Both outputs are 0 after such an edge.
- R4: `long_gap` is 1 for exactly one clock cycle. It is set by the edge that samples `rd_strobe` low for the (SHORT_LEN+LONG_LEN)-th consecutive time, which is LONG_LEN edges (default 8) after the edge that set `short_gap`.
- R5: A strobe sampled high after `short_gap` but before `long_gap` clears and disarms the long stage. No `long_gap` follows until a new `short_gap` and a full LONG_LEN further strobe-free edges.
- R6: Within one strobe-free run, each of `short_gap` and `long_gap` fires at most once, however long the run lasts.
- R7: `short_gap` and `long_gap` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_strobe | input | 1 | Synchronised read strobe level; 1 = byte received on this edge |
| short_gap | output | 1 | One-cycle pulse: end of data block detected |
| long_gap | output | 1 | One-cycle pulse: check-word time reached |

## Verification
Both outputs are registered. `short_gap` is due right after the SHORT_LEN-th strobe-free edge. `long_gap` is due right after the (SHORT_LEN+LONG_LEN)-th one. The bench drives `rd_strobe` on the falling edge and lets one rising edge sample it. It compares the outputs on the next falling edge against a model that tracks only the current strobe-free run length, so each check falls half a cycle after the edge that should have produced the result. Directed runs that stop one edge short of each limit, or that break the long count, sit beside random run lengths.

// File: rtl/gap_pkg.sv
package gap_pkg;
  // Default consecutive strobe-free edges before the short gap is reported.
  localparam int unsigned SHORT_LEN_DEF = 2;
  // Default further edges, counted after the short gap, before the long gap.
  localparam int unsigned LONG_LEN_DEF  = 8;

  // Width of a counter that must hold the values 0 .. limit.
  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/gap_stage.sv
// One saturating count stage. It advances on every edge that has adv high,
// emits a one-cycle pulse when it reaches LIMIT, then holds until cleared.
module gap_stage #(
  parameter int unsigned LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic pulse,
  output logic done
);
  localparam int unsigned CW = gap_pkg::cnt_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else if (clr) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else if (adv && cnt_q != TOP) begin
      cnt_q <= cnt_q + 1'b1;
      pulse <= (cnt_q == LAST);
    end else begin
      pulse <= 1'b0;
    end
  end

  assign done = (cnt_q == TOP);
endmodule

// File: rtl/gap_detector.sv
module gap_detector #(
  parameter int unsigned SHORT_LEN = gap_pkg::SHORT_LEN_DEF,
  parameter int unsigned LONG_LEN  = gap_pkg::LONG_LEN_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_strobe,
  output logic short_gap,
  output logic long_gap
);
  localparam int unsigned NSTAGE = 2;

  logic [NSTAGE-1:0] st_adv;
  logic [NSTAGE-1:0] st_pulse;
  logic [NSTAGE-1:0] st_done;

  // Stage 0 counts every strobe-free edge; stage 1 is armed by stage 0.
  assign st_adv[0] = 1'b1;
  assign st_adv[1] = st_done[0];

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    localparam int unsigned LIM = (g == 0) ? SHORT_LEN : LONG_LEN;
    gap_stage #(.LIMIT(LIM)) u_stage (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (rd_strobe),
      .adv  (st_adv[g]),
      .pulse(st_pulse[g]),
      .done (st_done[g])
    );
  end

  assign short_gap = st_pulse[0];
  assign long_gap  = st_pulse[1];
endmodule

// File: rtl/gap_detector_chk.sv
module gap_detector_chk #(
  parameter int unsigned SHORT_LEN = 2,
  parameter int unsigned LONG_LEN  = 8
) (
  input logic clk,
  input logic rst_n,
  input logic rd_strobe,
  input logic short_gap,
  input logic long_gap
);
  localparam int unsigned CW = gap_pkg::cnt_width(LONG_LEN + 1);

  // Edges since the short pulse became visible, cleared by any strobe.
  logic [CW-1:0] since_short;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_short <= '0;
    else if (rd_strobe) since_short <= '0;
    else if (short_gap) since_short <= CW'(1);
    else if (since_short != '0 && since_short != CW'(LONG_LEN + 1))
      since_short <= since_short + 1'b1;
  end

  // R2
  short_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    short_gap |=> !short_gap);

  // R4
  long_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    long_gap |=> !long_gap);

  // R3
  strobe_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> (!short_gap && !long_gap));

  // R2
  short_after_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(short_gap) |-> !$past(rd_strobe));

  // R5
  long_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    long_gap |-> since_short == CW'(LONG_LEN));

  // R7
  exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(short_gap && long_gap));
endmodule

bind gap_detector gap_detector_chk #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe),
  .short_gap(short_gap), .long_gap(long_gap)
);

// File: tb/gap_detector_tb.sv
module gap_detector_tb;
  localparam int unsigned SHORT_LEN = 2;
  localparam int unsigned LONG_LEN  = 8;
  localparam int unsigned FULL_RUN  = SHORT_LEN + LONG_LEN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_strobe = 1'b0;
  logic short_gap, long_gap;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  int unsigned run = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  gap_detector #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe),
    .short_gap(short_gap), .long_gap(long_gap)
  );

  function automatic bit exp_short(input int unsigned r);
    return r == SHORT_LEN;
  endfunction

  function automatic bit exp_long(input int unsigned r);
    return r == FULL_RUN;
  endfunction

  task automatic check(input string req, input string what, input bit got, input bit exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b (run %0d)", req, what, got, exp, run);
    end
  endtask

  // Drive one strobe value, let one edge sample it, check on the falling edge.
  task automatic step(input bit s, input string rs, input string rl);
    rd_strobe = s;
    @(posedge clk);
    if (s) run = 0;
    else if (run <= FULL_RUN) run++;
    @(negedge clk);
    check(rs, "short_gap", short_gap, exp_short(run));
    check(rl, "long_gap", long_gap, exp_long(run));
    check("R7", "both pulses", short_gap && long_gap, 1'b0);
  endtask

  task automatic miss_run(input int unsigned n, input string rs, input string rl);
    for (int i = 0; i < n; i++) step(1'b0, rs, rl);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd917);
    // R1: outputs quiet in reset
    repeat (3) @(negedge clk);
    check("R1", "short_gap in reset", short_gap, 1'b0);
    check("R1", "long_gap in reset", long_gap, 1'b0);
    rd_strobe = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    run = 0;
    step(1'b1, "R1", "R1");
    step(1'b0, "R1", "R1");

    // R3: a single miss then a strobe gives nothing
    step(1'b1, "R3", "R3");
    step(1'b0, "R3", "R3");
    step(1'b1, "R3", "R3");

    // R2 and R4: full gap, pulses at exact edges
    miss_run(FULL_RUN, "R2", "R4");

    // R6: long run after both pulses, no repeats
    miss_run(20, "R6", "R6");
    step(1'b1, "R6", "R6");

    // R5: break long count one edge before the limit
    miss_run(FULL_RUN - 1, "R5", "R5");
    step(1'b1, "R5", "R5");
    miss_run(FULL_RUN, "R5", "R5");
    step(1'b1, "R5", "R5");

    // Random run lengths around the limits
    for (int k = 0; k < 400; k++) begin
      int unsigned len;
      len = $urandom_range(0, FULL_RUN + 4);
      miss_run(len, "R2", "R4");
      step(1'b1, "R3", "R5");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule